// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block paces refresh work for an asynchronous DRAM whose rows must all be refreshed inside a fixed retention window. The device needs 1,024 refreshes every 16 ms, which is one every 15.6 µs on average. A down-counting interval timer, loaded from the `INTERVAL` parameter (1560 cycles at 100 MHz by default), raises a one-cycle `due_o` pulse each time it expires. Each pulse adds one entry to a backlog counter. The counter stops at `PEND_MAX` (8) so that postponed refreshes can later be caught up in a burst.

The backlog drives a request/acknowledge pair toward an access arbiter. A small state machine shows the depth of the backlog. `ST_IDLE` means nothing is owed. `ST_PEND` means one or more refreshes are owed and `req_o` is raised. `ST_URGENT` means at least `URGENT_LVL` (4) are owed and `urgent_o` is raised as well. The transitions are named as follows:
- IDLE→PEND (first due pulse)
- PEND→URGENT (backlog reaches the urgent level)
- URGENT→PEND (backlog drops below it)
- PEND→IDLE (backlog empties)

`cbr_mode_i` selects the refresh flavour:
- **Row-addressed (0):** RAS falls with both CAS strobes high. The arbiter presents the 10-bit `row_o` from the block's own counter, and this counter advances on every accepted grant.
- **CAS-before-RAS (1):** the device supplies its own row. `row_o` reads zero and the counter holds.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `due_o` is high after edge number `INTERVAL-1` and stays high for exactly one cycle. It repeats every `INTERVAL` cycles from then on.
- R2: A synchronous active-high `rst_i` has these effects at the next edge:
  - `pending_o` becomes 0 and `row_o` becomes 0.
  - `req_o`, `urgent_o` and `due_o` go low.
  - The interval restarts.
- R3: Each due pulse adds one to `pending_o`, which saturates at 8. A due pulse that arrives while the count is 8 is lost.
- R4: An accepted grant (`ack_i` high while `req_o` is high) subtracts one from `pending_o`. A due pulse and an accepted grant in the same cycle leave the count unchanged.
- R5: `req_o` is high exactly when `pending_o` is non-zero. `ack_i` while `req_o` is low has no effect on any output.
- R6: `urgent_o` is high exactly when `pending_o` is 4 or more.
- R7: With `cbr_mode_i`=0, each accepted grant advances the row counter by one, and the counter wraps from 1023 to 0. `row_o` shows the counter.
- R8: With `cbr_mode_i`=1, `row_o` reads 0 and accepted grants still decrement `pending_o`. The row counter does not move, which shows up as the same `row_o` value once the mode returns to 0.
- R9: The state machine moves through the states `ST_IDLE`, `ST_PEND` and `ST_URGENT` only along the four named transitions. Its outputs `req_o` and `urgent_o` change in the same cycle as `pending_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cbr_mode_i | input | 1 | 0 = row-addressed refresh, 1 = CAS-before-RAS refresh |
| ack_i | input | 1 | Grant from the access arbiter |
| req_o | output | 1 | A refresh is owed |
| urgent_o | output | 1 | Backlog has reached the urgent level |
| due_o | output | 1 | One-cycle interval expiry pulse |
| pending_o | output | PEND_W (4) | Number of refreshes owed |
| row_o | output | ROW_W (10) | Row for the next row-addressed refresh; 0 in CAS-before-RAS mode |

## Verification
All registered results (`pending_o`, `req_o`, `urgent_o`, the row counter and the timer behind `due_o`) settle one edge after the inputs that cause them. `row_o` additionally follows `cbr_mode_i` with no delay. The driver applies inputs on the falling edge and pushes the values its model predicts for after the next rising edge. The monitor compares these values 5 ns after that rising edge, so each expectation is matched to exactly one edge. With a short `INTERVAL`, the bench covers saturation, coincident due pulses and grants, grants while idle, the mode switch and a full row wrap.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_URGENT = 2'd2
    } rfsh_state_e;

    localparam int unsigned DEF_INTERVAL   = 1560;
    localparam int unsigned DEF_ROW_W      = 10;
    localparam int unsigned DEF_PEND_MAX   = 8;
    localparam int unsigned DEF_URGENT_LVL = 4;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned INTERVAL = 1560
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic due_o
);
    localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

    generate
        if (INTERVAL > 1) begin : g_count
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk_i) begin
                if (rst_i)
                    cnt_q <= RELOAD;
                else if (cnt_q == '0)
                    cnt_q <= RELOAD;
                else
                    cnt_q <= cnt_q - 1'b1;
            end

            assign due_o = (cnt_q == '0);

            // A pulse never lasts more than one cycle
            AST_DUE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
                due_o |=> !due_o); // R1
        end else begin : g_every
            logic run_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) run_q <= 1'b0;
                else       run_q <= 1'b1;
            end
            assign due_o = run_q;
        end
    endgenerate
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog
    import refresh_pkg::*;
#(
    parameter int unsigned PEND_MAX   = 8,
    parameter int unsigned URGENT_LVL = 4,
    parameter int unsigned PEND_W     = $clog2(PEND_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              due_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic              urgent_o,
    output logic [PEND_W-1:0] pending_o
);
    localparam logic [PEND_W-1:0] FULL = PEND_W'(PEND_MAX);
    localparam logic [PEND_W-1:0] URG  = PEND_W'(URGENT_LVL);

    rfsh_state_e       state_q, state_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic              ack_ok;

    assign ack_ok = ack_i && req_o;

    always_comb begin
        pend_d = pend_q;
        if (due_i && !ack_ok && pend_q != FULL)
            pend_d = pend_q + 1'b1;
        else if (ack_ok && !due_i)
            pend_d = pend_q - 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pend_d != '0) state_d = ST_PEND;
            ST_PEND: begin
                if (pend_d == '0)       state_d = ST_IDLE;
                else if (pend_d >= URG) state_d = ST_URGENT;
            end
            ST_URGENT: if (pend_d < URG) state_d = ST_PEND;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        req_o    = 1'b0;
        urgent_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PEND:   req_o = 1'b1;
            ST_URGENT: begin
                req_o    = 1'b1;
                urgent_o = 1'b1;
            end
            default:   ;
        endcase
    end

    assign pending_o = pend_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        pend_q <= FULL); // R3
    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_q == FULL && due_i && !ack_ok) |=> pend_q == FULL); // R3
    AST_ACK_DEC: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_ok && !due_i) |=> pend_q == $past(pend_q) - 1'b1); // R4
    AST_REQ_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        req_o == (pend_q != '0)); // R5
    AST_URG_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        urgent_o == (pend_q >= URG)); // R6
    AST_NO_SKIP_URGENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE) |=> state_q != ST_URGENT); // R9
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int unsigned ROW_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_i,
    input  logic             hold_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            row_q <= '0;
        else if (step_i && !hold_i)
            row_q <= row_q + 1'b1;
    end

    assign row_o = row_q;

    AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !hold_i) |=> row_q == ROW_W'($past(row_q) + 1'b1)); // R7
    AST_ROW_HOLD_CBR: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> $stable(row_q)); // R8
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refresh_pkg::*;
#(
    parameter int unsigned INTERVAL   = DEF_INTERVAL,
    parameter int unsigned ROW_W      = DEF_ROW_W,
    parameter int unsigned PEND_MAX   = DEF_PEND_MAX,
    parameter int unsigned URGENT_LVL = DEF_URGENT_LVL,
    parameter int unsigned PEND_W     = $clog2(PEND_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cbr_mode_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic              urgent_o,
    output logic              due_o,
    output logic [PEND_W-1:0] pending_o,
    output logic [ROW_W-1:0]  row_o
);
    logic             due;
    logic             req;
    logic [ROW_W-1:0] row_cnt;

    rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .due_o (due)
    );

    rfsh_backlog #(
        .PEND_MAX  (PEND_MAX),
        .URGENT_LVL(URGENT_LVL),
        .PEND_W    (PEND_W)
    ) u_backlog (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .due_i    (due),
        .ack_i    (ack_i),
        .req_o    (req),
        .urgent_o (urgent_o),
        .pending_o(pending_o)
    );

    rfsh_row_counter #(.ROW_W(ROW_W)) u_row (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .step_i(ack_i && req),
        .hold_i(cbr_mode_i),
        .row_o (row_cnt)
    );

    assign req_o = req;
    assign due_o = due;
    assign row_o = cbr_mode_i ? '0 : row_cnt;

    AST_URGENT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        urgent_o |-> req_o); // R6
    AST_IDLE_ACK_NOOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!req_o && !due_o) |=> pending_o == '0); // R5
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
    localparam int IV = 8;

    typedef struct {
        logic        due;
        logic        req;
        logic        urg;
        logic [3:0]  pend;
        logic [9:0]  row;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cbr = 1'b0;
    logic       ack = 1'b0;
    logic       req, urg, due;
    logic [3:0] pend;
    logic [9:0] row;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    int m_cnt = IV - 1;
    int m_pend = 0;
    int m_row = 0;

    always #10 clk = ~clk;

    dram_refresh_sched #(.INTERVAL(IV)) u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .cbr_mode_i(cbr),
        .ack_i     (ack),
        .req_o     (req),
        .urgent_o  (urg),
        .due_o     (due),
        .pending_o (pend),
        .row_o     (row)
    );

    // driver: apply inputs, predict outputs after the next rising edge
    task automatic step(input logic r, input logic m, input logic a, input string tag);
        exp_t e;
        bit   due_now, acc;
        @(negedge clk);
        rst = r; cbr = m; ack = a;
        if (r) begin
            m_cnt = IV - 1; m_pend = 0; m_row = 0;
        end else begin
            due_now = (m_cnt == 0);
            acc = a && (m_pend != 0);
            if (due_now && !acc && m_pend < 8) m_pend++;
            else if (acc && !due_now) m_pend--;
            if (acc && !m) m_row = (m_row + 1) % 1024;
            m_cnt = (m_cnt == 0) ? IV - 1 : m_cnt - 1;
        end
        e.due  = (m_cnt == 0);
        e.req  = (m_pend != 0);
        e.urg  = (m_pend >= 4);
        e.pend = 4'(m_pend);
        e.row  = m ? 10'd0 : 10'(m_row);
        e.tag  = tag;
        q.push_back(e);
    endtask

    // monitor: compare 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            n_run++;
            bad = 0;
            if (due !== e.due) begin
                $display("FAIL R1 [%s] due=%0b expected %0b", e.tag, due, e.due); bad = 1;
            end
            if (pend !== e.pend) begin
                $display("FAIL R3/R4 [%s] pending=%0d expected %0d", e.tag, pend, e.pend); bad = 1;
            end
            if (req !== e.req) begin
                $display("FAIL R5 [%s] req=%0b expected %0b", e.tag, req, e.req); bad = 1;
            end
            if (urg !== e.urg) begin
                $display("FAIL R6 [%s] urgent=%0b expected %0b", e.tag, urg, e.urg); bad = 1;
            end
            if (row !== e.row) begin
                $display("FAIL R7/R8 [%s] row=%0d expected %0d", e.tag, row, e.row); bad = 1;
            end
            if (bad) n_fail++;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired: state=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R2: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R2 reset");
        // R1 R3 R6 R9: backlog builds, urgent raised, saturates at 8
        for (int i = 0; i < 80; i++) step(0, 0, 0, "R3 fill");
        // R4 R7: a few grants in row-addressed mode
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R4 R7 grant");
        // R8: grants in CAS-before-RAS mode, row counter must hold
        for (int i = 0; i < 12; i++) step(0, 1, 1, "R8 cbr grant");
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R8 row held");
        // R5 R7 R4: continuous grants drain and idle-ack, row wraps
        for (int i = 0; i < 8400; i++) step(0, 0, 1, "R5 R7 wrap");
        // R2: reset mid-run
        for (int i = 0; i < 20; i++) step(0, 0, 0, "R9 refill");
        for (int i = 0; i < 2; i++) step(1, 0, 0, "R2 mid reset");
        for (int i = 0; i < 12; i++) step(0, 0, 0, "R1 restart");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule